// File: doc/BRIEF.md
# Unified L1 Cache Access Router

This block sits in front of a first-level data store that is split into two parts. One part is a directly addressed scratchpad. The other is a direct-mapped tagged cache with 128-byte lines. Each request names an address space, an operation (load or store), a word address and write data. The router classifies the request and picks one of four paths:

- **Shared space** goes to the scratchpad and never touches the tags.
- **Local space** uses the tagged cache with normal hit, miss and fill handling.
- **Plain global space** always probes the tags, clears any matching line, and is then serviced uncached by the next level.
- **Read-only global loads** leave on a separate read-only port.

Only one request is in flight at a time. The next level speaks a valid/ready request channel and a response channel. A line fill returns one 32-bit beat per response cycle, in ascending word order from the line base. A single-word read or a store acknowledge returns one beat. A one-cycle flush input drops every cache line at once and keeps the scratchpad contents.

Top module: `l1_access_router`

## Requirements
- R1: After reset, in_ready is 1, out_valid, nl_req_valid and ro_req_valid are 0, and every cache line is invalid.
- R2: in_space 0 (shared) reads or writes scratchpad word (address/4) mod SPAD_WORDS. Such a request completes with out_valid one cycle after acceptance, makes no tag lookup, changes no line valid bit and sends nothing to either port.
- R3: Local (in_space 1) and global requests look up the tag store. A local load to a valid line with a matching tag returns the cached word one cycle after acceptance, with no next-level request.
- R4: A local load that misses allocates its set and issues one next-level line fill (nl_req_line 1, nl_req_addr the line base). After all 32 beats have arrived it returns the requested word and marks the line valid.
- R5: A local store writes through to the next level as a single-word write. On a hit it also updates the cached word. On a miss it allocates nothing, so a later load to that line still misses.
- R6: A global load (in_space 2) is always a single-word next-level read, never allocates, and invalidates a resident line whose tag matches.
- R7: A global store (in_space 2, or in_space 3 with in_write 1) invalidates a matching line and raises nl_req_valid with nl_req_write 1 on the same clock edge on which it is accepted.
- R8: A read-only load (in_space 3, in_write 0) is issued on ro_req_addr, returns ro_rsp_data, and causes no next-level traffic and no tag change.
- R9: in_ready stays 0 from acceptance of a request that uses either port until its completion. A next-level request holds its address until nl_req_ready.
- R10: flush clears all line valid bits in one cycle and leaves the scratchpad contents unchanged.
- R11: Every accepted request produces exactly one out_valid pulse one cycle wide. For loads, out_data carries the loaded word at that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop all cache lines this cycle |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_space | input | 2 | 0 shared, 1 local, 2 global, 3 read-only global |
| in_write | input | 1 | 1 store, 0 load |
| in_addr | input | ADDR_W | Byte address (word aligned) |
| in_wdata | input | DATA_W | Store data |
| out_valid | output | 1 | Request completed |
| out_data | output | DATA_W | Load result |
| nl_req_valid | output | 1 | Next-level request valid |
| nl_req_ready | input | 1 | Next level takes the request |
| nl_req_write | output | 1 | Next-level request is a write |
| nl_req_line | output | 1 | Next-level request is a whole-line fill |
| nl_req_addr | output | ADDR_W | Next-level address |
| nl_req_wdata | output | DATA_W | Next-level write data |
| nl_rsp_valid | input | 1 | Response beat valid |
| nl_rsp_data | input | DATA_W | Response beat data |
| ro_req_valid | output | 1 | Read-only port request valid |
| ro_req_ready | input | 1 | Read-only port takes the request |
| ro_req_addr | output | ADDR_W | Read-only port address |
| ro_rsp_valid | input | 1 | Read-only response valid |
| ro_rsp_data | input | DATA_W | Read-only response data |

## Verification
The assertions take several things for granted about the inputs:
- A response on either port never arrives before the matching request handshake.
- A fill returns exactly one beat per word of the line.
- Addresses are word aligned.

The bench's port models keep to this. Each model answers only after taking the request, sends 32 beats for a fill and one beat otherwise, and may insert idle cycles between beats. The bench also raises flush and new requests only while the router is idle, and generates only aligned addresses in a small window. That window makes hits, conflicts and invalidations of resident lines frequent.

// File: rtl/l1r_pkg.sv
package l1r_pkg;

  typedef enum logic [1:0] {
    SPC_SHARED = 2'd0,
    SPC_LOCAL  = 2'd1,
    SPC_GLOBAL = 2'd2,
    SPC_RDONLY = 2'd3
  } space_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NL_ISSUE,
    ST_NL_COLLECT,
    ST_RO_ISSUE,
    ST_RO_WAIT
  } state_e;

endpackage

// File: rtl/l1r_word_ram.sv
module l1r_word_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/l1r_tag_store.sv
module l1r_tag_store #(
  parameter int SETS  = 8,
  parameter int TAG_W = 22,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lookup_en,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  input  logic             alloc_en,
  input  logic             inval_en,
  input  logic             fill_done,
  input  logic [SET_W-1:0] fill_set,
  output logic [SETS-1:0]  valid_bits
);

  logic [TAG_W-1:0] tag_q [SETS];
  logic [SETS-1:0]  valid_q;

  assign hit        = lookup_en && valid_q[lk_set] && (tag_q[lk_set] == lk_tag);
  assign valid_bits = valid_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel_lk, sel_fill, clr;
    assign sel_lk   = (lk_set == SET_W'(s));
    assign sel_fill = (fill_set == SET_W'(s));
    assign clr      = sel_lk && (alloc_en || (inval_en && hit));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    valid_q[s] <= 1'b0;
      else if (flush)                valid_q[s] <= 1'b0;
      else if (clr)                  valid_q[s] <= 1'b0;
      else if (fill_done && sel_fill) valid_q[s] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (alloc_en && sel_lk) tag_q[s] <= lk_tag;
    end
  end

endmodule

// File: rtl/l1_access_router.sv
module l1_access_router #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SETS       = 8,
  parameter int SPAD_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_space,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              nl_req_valid,
  input  logic              nl_req_ready,
  output logic              nl_req_write,
  output logic              nl_req_line,
  output logic [ADDR_W-1:0] nl_req_addr,
  output logic [DATA_W-1:0] nl_req_wdata,
  input  logic              nl_rsp_valid,
  input  logic [DATA_W-1:0] nl_rsp_data,
  output logic              ro_req_valid,
  input  logic              ro_req_ready,
  output logic [ADDR_W-1:0] ro_req_addr,
  input  logic              ro_rsp_valid,
  input  logic [DATA_W-1:0] ro_rsp_data
);
  import l1r_pkg::*;

  localparam int BYTE_OFF = $clog2(DATA_W / 8);
  localparam int LINE_OFF = $clog2(LINE_BYTES);
  localparam int BEATS    = LINE_BYTES / (DATA_W / 8);
  localparam int BEAT_W   = $clog2(BEATS);
  localparam int SET_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - LINE_OFF - SET_W;
  localparam int SPAD_AW  = $clog2(SPAD_WORDS);
  localparam int CACHE_AW = SET_W + BEAT_W;

  // address arithmetic
  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[LINE_OFF +: SET_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [BEAT_W-1:0] beat_of(input logic [ADDR_W-1:0] a);
    return a[BYTE_OFF +: BEAT_W];
  endfunction
  function automatic logic [SPAD_AW-1:0] spad_of(input logic [ADDR_W-1:0] a);
    return a[BYTE_OFF +: SPAD_AW];
  endfunction
  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:LINE_OFF], {LINE_OFF{1'b0}}};
  endfunction

  logic unused_low_bits;
  assign unused_low_bits = ^in_addr[BYTE_OFF-1:0];

  state_e state_q;

  logic [ADDR_W-1:0] rq_addr_q;
  logic [DATA_W-1:0] rq_wdata_q;
  logic              rq_write_q;
  logic              rq_line_q;
  logic [BEAT_W-1:0] rq_beat_q;
  logic [SET_W-1:0]  rq_set_q;
  logic [BEAT_W-1:0] beat_cnt_q;
  logic [DATA_W-1:0] cap_q;

  // request classification (named events for the checker)
  space_e sp;
  logic   accept, is_shared, is_local, is_gpath, is_roload;
  logic   lookup_en, tag_hit, alloc_en, inval_en;
  logic   fill_beat, fill_done, rsp_done;
  logic [SETS-1:0] valid_bits;

  assign sp        = space_e'(in_space);
  assign in_ready  = (state_q == ST_IDLE) && !flush;
  assign accept    = in_valid && in_ready;
  assign is_shared = (sp == SPC_SHARED);
  assign is_local  = (sp == SPC_LOCAL);
  assign is_gpath  = (sp == SPC_GLOBAL) || ((sp == SPC_RDONLY) && in_write);
  assign is_roload = (sp == SPC_RDONLY) && !in_write;

  assign lookup_en = accept && (is_local || is_gpath);
  assign alloc_en  = accept && is_local && !in_write && !tag_hit;
  assign inval_en  = accept && is_gpath;

  assign fill_beat = (state_q == ST_NL_COLLECT) && nl_rsp_valid && rq_line_q;
  assign fill_done = fill_beat && (beat_cnt_q == BEAT_W'(BEATS - 1));
  assign rsp_done  = (state_q == ST_NL_COLLECT) && nl_rsp_valid &&
                     (!rq_line_q || (beat_cnt_q == BEAT_W'(BEATS - 1)));

  l1r_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lookup_en (lookup_en),
    .lk_set    (set_of(in_addr)),
    .lk_tag    (tag_of(in_addr)),
    .hit       (tag_hit),
    .alloc_en  (alloc_en),
    .inval_en  (inval_en),
    .fill_done (fill_done),
    .fill_set  (rq_set_q),
    .valid_bits(valid_bits)
  );

  // scratchpad
  logic              spad_we;
  logic [DATA_W-1:0] spad_rdata;
  assign spad_we = accept && is_shared && in_write;

  l1r_word_ram #(.DEPTH(SPAD_WORDS), .W(DATA_W)) u_spad (
    .clk  (clk),
    .we   (spad_we),
    .waddr(spad_of(in_addr)),
    .wdata(in_wdata),
    .raddr(spad_of(in_addr)),
    .rdata(spad_rdata)
  );

  // cache line data
  logic                cd_we;
  logic [CACHE_AW-1:0] cd_waddr;
  logic [DATA_W-1:0]   cd_wdata;
  logic [DATA_W-1:0]   cd_rdata;
  logic                st_hit;

  assign st_hit = accept && is_local && in_write && tag_hit;

  always_comb begin
    cd_we    = 1'b0;
    cd_waddr = {set_of(in_addr), beat_of(in_addr)};
    cd_wdata = in_wdata;
    if (fill_beat) begin
      cd_we    = 1'b1;
      cd_waddr = {rq_set_q, beat_cnt_q};
      cd_wdata = nl_rsp_data;
    end else if (st_hit) begin
      cd_we = 1'b1;
    end
  end

  l1r_word_ram #(.DEPTH(SETS * BEATS), .W(DATA_W)) u_lines (
    .clk  (clk),
    .we   (cd_we),
    .waddr(cd_waddr),
    .wdata(cd_wdata),
    .raddr({set_of(in_addr), beat_of(in_addr)}),
    .rdata(cd_rdata)
  );

  // control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      out_valid  <= 1'b0;
      out_data   <= '0;
      rq_addr_q  <= '0;
      rq_wdata_q <= '0;
      rq_write_q <= 1'b0;
      rq_line_q  <= 1'b0;
      rq_beat_q  <= '0;
      rq_set_q   <= '0;
      beat_cnt_q <= '0;
      cap_q      <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (is_shared) begin
              out_valid <= 1'b1;
              out_data  <= in_write ? '0 : spad_rdata;
            end else if (is_local && !in_write && tag_hit) begin
              out_valid <= 1'b1;
              out_data  <= cd_rdata;
            end else if (is_roload) begin
              rq_addr_q <= in_addr;
              state_q   <= ST_RO_ISSUE;
            end else begin
              rq_addr_q  <= alloc_en ? line_base(in_addr) : in_addr;
              rq_line_q  <= alloc_en;
              rq_write_q <= in_write;
              rq_wdata_q <= in_wdata;
              rq_beat_q  <= beat_of(in_addr);
              rq_set_q   <= set_of(in_addr);
              state_q    <= ST_NL_ISSUE;
            end
          end
        end
        ST_NL_ISSUE: begin
          if (nl_req_ready) begin
            beat_cnt_q <= '0;
            state_q    <= ST_NL_COLLECT;
          end
        end
        ST_NL_COLLECT: begin
          if (nl_rsp_valid) begin
            beat_cnt_q <= beat_cnt_q + 1'b1;
            if (beat_cnt_q == rq_beat_q) cap_q <= nl_rsp_data;
            if (rsp_done) begin
              state_q   <= ST_IDLE;
              out_valid <= 1'b1;
              if (rq_write_q)                                  out_data <= '0;
              else if (!rq_line_q || beat_cnt_q == rq_beat_q)  out_data <= nl_rsp_data;
              else                                             out_data <= cap_q;
            end
          end
        end
        ST_RO_ISSUE: begin
          if (ro_req_ready) state_q <= ST_RO_WAIT;
        end
        ST_RO_WAIT: begin
          if (ro_rsp_valid) begin
            state_q   <= ST_IDLE;
            out_valid <= 1'b1;
            out_data  <= ro_rsp_data;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign nl_req_valid = (state_q == ST_NL_ISSUE);
  assign nl_req_write = rq_write_q;
  assign nl_req_line  = rq_line_q;
  assign nl_req_addr  = rq_addr_q;
  assign nl_req_wdata = rq_wdata_q;
  assign ro_req_valid = (state_q == ST_RO_ISSUE);
  assign ro_req_addr  = rq_addr_q;

endmodule

// File: rtl/l1r_checker.sv
module l1r_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SETS       = 8,
  localparam int LINE_OFF  = $clog2(LINE_BYTES),
  localparam int SET_W     = $clog2(SETS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_space,
  input logic              in_write,
  input logic [ADDR_W-1:0] in_addr,
  input logic              nl_req_valid,
  input logic              nl_req_ready,
  input logic              nl_req_write,
  input logic [ADDR_W-1:0] nl_req_addr,
  input logic              ro_req_valid,
  input logic              lookup_en,
  input logic              tag_hit,
  input logic              alloc_en,
  input logic [SETS-1:0]   valid_bits
);

  logic acc, acc_sh, acc_mem, acc_g;
  assign acc     = in_valid && in_ready;
  assign acc_sh  = acc && (in_space == 2'd0);
  assign acc_g   = acc && ((in_space == 2'd2) || (in_space == 2'd3 && in_write));
  assign acc_mem = acc && ((in_space == 2'd1) || (in_space == 2'd2) || (in_space == 2'd3 && in_write));

  // R2
  shared_no_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sh |-> !lookup_en);

  // R2
  shared_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sh |=> $stable(valid_bits));

  // R3
  mem_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mem |-> lookup_en);

  // R6
  global_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_g && tag_hit) |=> !valid_bits[$past(in_addr[LINE_OFF +: SET_W])]);

  // R6
  global_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_g |-> !alloc_en);

  // R7
  gstore_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_g && in_write) |=> (nl_req_valid && nl_req_write));

  // R8
  ro_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_req_valid |-> !nl_req_valid);

  // R9
  single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_req_valid || ro_req_valid) |-> !in_ready);

  // R9
  nl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_req_valid && !nl_req_ready) |=> (nl_req_valid && $stable(nl_req_addr)));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_bits == '0));

endmodule

bind l1_access_router l1r_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
  .in_space(in_space), .in_write(in_write), .in_addr(in_addr),
  .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready), .nl_req_write(nl_req_write),
  .nl_req_addr(nl_req_addr), .ro_req_valid(ro_req_valid), .lookup_en(lookup_en),
  .tag_hit(tag_hit), .alloc_en(alloc_en), .valid_bits(valid_bits)
);

// File: tb/sim_l1_access_router.sv
module sim_l1_access_router;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NBEAT = 32;
  localparam int NSET = 8;
  localparam int NSPAD = 64;
  localparam logic [1:0] SH = 2'd0, LO = 2'd1, GL = 2'd2, RD = 2'd3;

  logic clk = 1'b0;
  logic rst_n;
  logic flush;
  logic in_valid, in_ready, in_write;
  logic [1:0] in_space;
  logic [AW-1:0] in_addr;
  logic [DW-1:0] in_wdata;
  logic out_valid;
  logic [DW-1:0] out_data;
  logic nl_req_valid, nl_req_ready, nl_req_write, nl_req_line;
  logic [AW-1:0] nl_req_addr;
  logic [DW-1:0] nl_req_wdata;
  logic nl_rsp_valid;
  logic [DW-1:0] nl_rsp_data;
  logic ro_req_valid, ro_req_ready;
  logic [AW-1:0] ro_req_addr;
  logic ro_rsp_valid;
  logic [DW-1:0] ro_rsp_data;

  l1_access_router u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_space(in_space), .in_write(in_write),
    .in_addr(in_addr), .in_wdata(in_wdata), .out_valid(out_valid), .out_data(out_data),
    .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready), .nl_req_write(nl_req_write),
    .nl_req_line(nl_req_line), .nl_req_addr(nl_req_addr), .nl_req_wdata(nl_req_wdata),
    .nl_rsp_valid(nl_rsp_valid), .nl_rsp_data(nl_rsp_data),
    .ro_req_valid(ro_req_valid), .ro_req_ready(ro_req_ready), .ro_req_addr(ro_req_addr),
    .ro_rsp_valid(ro_rsp_valid), .ro_rsp_data(ro_rsp_data)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // next-level and read-only models
  logic [31:0] nl_mem [logic [31:0]];
  function automatic logic [31:0] bg_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A17C3E1;
  endfunction
  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return nl_mem.exists(a) ? nl_mem[a] : bg_word(a);
  endfunction
  function automatic logic [31:0] ro_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h0F0F0000;
  endfunction
  function automatic logic [2:0] set_f(input logic [31:0] a);
    return a[9:7];
  endfunction
  function automatic logic [21:0] tag_f(input logic [31:0] a);
    return a[31:10];
  endfunction

  int nl_cnt = 0, ro_cnt = 0;
  logic [31:0] nl_last_addr, nl_last_wdata, ro_last_addr;
  logic nl_last_write, nl_last_line;

  initial begin
    nl_req_ready = 0; nl_rsp_valid = 0; nl_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && nl_req_valid === 1'b1) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        nl_req_ready = 1;
        nl_cnt++;
        nl_last_addr = nl_req_addr; nl_last_write = nl_req_write;
        nl_last_line = nl_req_line; nl_last_wdata = nl_req_wdata;
        if (nl_req_write) nl_mem[nl_req_addr] = nl_req_wdata;
        @(negedge clk);
        nl_req_ready = 0;
        for (int b = 0; b < (nl_last_line ? NBEAT : 1); b++) begin
          if ($urandom_range(0, 3) == 0) @(negedge clk);
          nl_rsp_valid = 1;
          nl_rsp_data  = nl_last_write ? '0 : mem_rd(nl_last_addr + 32'(4 * b));
          @(negedge clk);
          nl_rsp_valid = 0;
        end
      end
    end
  end

  initial begin
    ro_req_ready = 0; ro_rsp_valid = 0; ro_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && ro_req_valid === 1'b1) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        ro_req_ready = 1;
        ro_cnt++;
        ro_last_addr = ro_req_addr;
        @(negedge clk);
        ro_req_ready = 0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        ro_rsp_valid = 1;
        ro_rsp_data  = ro_word(ro_last_addr);
        @(negedge clk);
        ro_rsp_valid = 0;
      end
    end
  end

  // expected tag state and scratchpad contents
  bit          exp_valid [NSET];
  logic [21:0] exp_tag   [NSET];
  logic [31:0] exp_spad  [NSPAD];

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    for (int s = 0; s < NSET; s++) exp_valid[s] = 0;
  endtask

  task automatic run(input logic [1:0] sp, input bit wr, input logic [31:0] a,
                     input logic [31:0] wd);
    int nl0, ro0, lat;
    bit hit, gpath, ready_ok, first_nl, first_nlw;
    logic [31:0] exp_d, rd;
    string rq;
    nl0 = nl_cnt; ro0 = ro_cnt;
    hit   = exp_valid[set_f(a)] && exp_tag[set_f(a)] == tag_f(a);
    gpath = (sp == GL) || (sp == RD && wr);
    exp_d = (sp == SH) ? exp_spad[a[7:2]] : (sp == RD) ? ro_word(a) : mem_rd(a);

    @(negedge clk);
    in_valid = 1; in_space = sp; in_write = wr; in_addr = a; in_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    lat = 1; ready_ok = 1; first_nl = nl_req_valid; first_nlw = nl_req_write;
    while (out_valid !== 1'b1 && lat < 3000) begin
      if (in_ready !== 1'b0) ready_ok = 0;
      @(negedge clk);
      lat++;
    end
    rd = out_data;
    check(out_valid === 1'b1, "R11", "completion pulse", 32'(out_valid), 1);
    @(negedge clk);
    check(out_valid === 1'b0, "R11", "pulse width", 32'(out_valid), 0);

    if (sp == SH) begin
      rq = "R2";
      check(lat == 1, rq, "shared latency", 32'(lat), 1);
      check(nl_cnt == nl0 && ro_cnt == ro0, rq, "shared port traffic", 32'(nl_cnt - nl0), 0);
      if (!wr) check(rd === exp_d, rq, "shared data", rd, exp_d);
      else exp_spad[a[7:2]] = wd;
    end else if (sp == LO && !wr && hit) begin
      rq = "R3";
      check(lat == 1, rq, "local hit latency", 32'(lat), 1);
      check(nl_cnt == nl0, rq, "local hit traffic", 32'(nl_cnt - nl0), 0);
      check(rd === exp_d, rq, "local hit data", rd, exp_d);
    end else if (sp == LO && !wr) begin
      rq = "R4";
      check(nl_cnt == nl0 + 1 && nl_last_line && !nl_last_write, rq, "fill request",
            32'(nl_cnt - nl0), 1);
      check(nl_last_addr === {a[31:7], 7'b0}, rq, "fill address", nl_last_addr, {a[31:7], 7'b0});
      check(rd === exp_d, rq, "fill word", rd, exp_d);
      check(ready_ok, "R9", "in_ready low during fill", 32'(ready_ok), 1);
      exp_valid[set_f(a)] = 1; exp_tag[set_f(a)] = tag_f(a);
    end else if (sp == RD && !wr) begin
      rq = "R8";
      check(ro_cnt == ro0 + 1 && nl_cnt == nl0, rq, "ro port only", 32'(ro_cnt - ro0), 1);
      check(ro_last_addr === a, rq, "ro address", ro_last_addr, a);
      check(rd === exp_d, rq, "ro data", rd, exp_d);
      check(ready_ok, "R9", "in_ready low during ro", 32'(ready_ok), 1);
    end else begin
      rq = (sp == LO) ? "R5" : (wr ? "R7" : "R6");
      check(nl_cnt == nl0 + 1 && !nl_last_line && nl_last_write == wr, rq, "single word access",
            32'(nl_cnt - nl0), 1);
      check(nl_last_addr === a, rq, "access address", nl_last_addr, a);
      if (wr) check(nl_last_wdata === wd, rq, "write data", nl_last_wdata, wd);
      else    check(rd === exp_d, rq, "uncached data", rd, exp_d);
      check(ready_ok, "R9", "in_ready low during access", 32'(ready_ok), 1);
      if (gpath && wr) check(first_nl && first_nlw, "R7", "issue on accept edge", 32'(first_nl), 1);
      if (gpath && hit) exp_valid[set_f(a)] = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      check(0, "R9", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; flush = 0; in_valid = 0; in_space = SH; in_write = 0;
    in_addr = '0; in_wdata = '0;
    for (int s = 0; s < NSET; s++) exp_valid[s] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports (line validity is seen by the first local loads missing)
    check(in_ready === 1'b1, "R1", "in_ready", 32'(in_ready), 1);
    check(out_valid === 1'b0, "R1", "out_valid", 32'(out_valid), 0);
    check(nl_req_valid === 1'b0 && ro_req_valid === 1'b0, "R1", "port requests",
          32'({nl_req_valid, ro_req_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R1", "idle after reset", 32'(in_ready), 1);

    // R2: fill the scratchpad, then read some of it back
    for (int i = 0; i < NSPAD; i++) run(SH, 1, 32'(i * 4), $urandom);
    for (int i = 0; i < 8; i++) run(SH, 0, 32'($urandom_range(0, 255) * 4), 0);

    // R4 then R3: miss fills, second access hits
    run(LO, 0, 32'h0000_0188, 0);
    run(LO, 0, 32'h0000_01FC, 0);
    run(LO, 0, 32'h0000_0180, 0);
    // R5: store hit updates line and writes through; load hits with new word
    run(LO, 1, 32'h0000_0184, 32'hCAFE_0001);
    run(LO, 0, 32'h0000_0184, 0);
    // R5: store miss writes around; later load misses
    run(LO, 1, 32'h0000_0A04, 32'hBEEF_0002);
    run(LO, 0, 32'h0000_0A04, 0);
    // R6: global load to resident line invalidates; local reload misses
    run(GL, 0, 32'h0000_0188, 0);
    run(LO, 0, 32'h0000_0188, 0);
    // R7: global store to resident line and via read-only space with write
    run(GL, 1, 32'h0000_0190, 32'h1111_2222);
    run(LO, 0, 32'h0000_0190, 0);
    run(RD, 1, 32'h0000_0194, 32'h3333_4444);
    run(LO, 0, 32'h0000_0194, 0);
    // R8: read-only load
    run(RD, 0, 32'h0000_0194, 0);
    run(LO, 0, 32'h0000_0198, 0);
    // conflict in one set
    run(LO, 0, 32'h0000_0580, 0);
    run(LO, 0, 32'h0000_0180, 0);
    // R10: flush drops lines, scratchpad kept
    do_flush();
    run(LO, 0, 32'h0000_0180, 0);
    run(SH, 0, 32'h0000_0010, 0);
    run(SH, 0, 32'h0000_00FC, 0);

    // constrained random mix
    for (int n = 0; n < 500; n++) begin
      int pick;
      logic [31:0] a;
      pick = $urandom_range(0, 99);
      a = 32'($urandom_range(0, 1023) * 4);
      if (pick < 3) do_flush();
      else if (pick < 18) run(SH, $urandom_range(0, 1) == 1, a, $urandom);
      else if (pick < 60) run(LO, $urandom_range(0, 3) == 0, a, $urandom);
      else if (pick < 82) run(GL, $urandom_range(0, 1) == 1, a, $urandom);
      else run(RD, $urandom_range(0, 4) == 0, a, $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule